// File: doc/BRIEF.md
# Sensor Baseband Command Controller

This block is the digital core of a wirelessly powered sensor. It listens to a demodulated command line that carries one half-bit per strobe, accepts a command only when every bit is a legal Manchester symbol and the parity is even, and then leaves its idle state for one of five operating states. Four of those states perform a single action (a tunneling pulse, an injection pulse, a channel-pointer step, or one readout) and fall back to idle. The fifth keeps digitizing and returning every channel in turn until a stop command arrives.

A readout asks the external converter for a sample of the selected channel. When the converter reports done, the block forms an uplink packet: a fixed preamble, the 8-bit result, and a 3-bit CRC. It sends the packet as a Manchester-coded level on `mod_out`, which drives the backscatter switch. A high level closes the switch and collapses the carrier.

Top module: `sensor_ctrl`

## Requirements
- R1: While and right after reset, `tun_en`, `inj_en`, `sel_en`, `adc_start` and `mod_out` are 0 and `ch_sel` is 0.
- R2: A command is 10 half-bits, one per `cmd_stb` cycle. They carry code[3], code[2], code[1], code[0] and then the parity bit. A 1 is the half-bit pair high,low and a 0 is low,high. A frame holding a pair 00 or 11 is discarded. A `cmd_sof` pulse throws away any partly received frame.
- R3: The five bits (code plus parity) must XOR to 0. Otherwise the frame is discarded and the machine stays idle.
- R4: In idle, code 1 starts tunneling, 2 injection, 3 channel select, 4 single readout and 5 continuous scan. Codes 0 and 6 to 15 are ignored. Commands arriving in states S1 to S4 are ignored.
- R5: Tunneling and injection hold `tun_en` or `inj_en` high for exactly PULSE_LEN cycles and then return to idle.
- R6: Channel select raises `sel_en` for one cycle. `ch_sel` then advances by one, wrapping from NUM_CH-1 to 0.
- R7: A single readout issues one `adc_start` pulse and waits for `adc_done`. It sends one packet built from `adc_data` sampled with `adc_done`, then returns to idle with `ch_sel` unchanged.
- R8: A packet is 19 bits, most significant first: preamble 11110000, the 8 data bits, the 3 CRC bits. Each bit lasts two half periods of HALF_CYC cycles. A 1 is high then low on `mod_out` and a 0 is low then high. `mod_out` is low between packets.
- R9: The CRC is the remainder of data·x^3 divided by x^3+x+1.
- R10: Continuous scan starts at channel 0 and reads channels 0,1,2,… with wrap-around, sending one packet per channel, without further commands.
- R11: A valid code 0 received during scan lets the current packet finish. The machine then returns to idle and issues no further `adc_start`.
- R12: At most one of `tun_en`, `inj_en`, `sel_en`, `adc_start` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_sof | input | 1 | Start-of-frame pulse, clears the command receiver |
| cmd_stb | input | 1 | One command half-bit is present |
| cmd_half | input | 1 | Half-bit level |
| adc_done | input | 1 | Converter result valid (one cycle) |
| adc_data | input | 8 | Converter result |
| tun_en | output | 1 | Tunneling controller enable |
| inj_en | output | 1 | Injection controller enable |
| sel_en | output | 1 | Channel-selection controller strobe |
| ch_sel | output | $clog2(NUM_CH) | Selected channel |
| adc_start | output | 1 | Converter start pulse |
| mod_out | output | 1 | Backscatter switch drive |

## Verification
Random commands are mixed with three corruption kinds: clean, parity flipped, and one Manchester pair forced to 00 or 11. Comparing enable run lengths and packet counts with the expected values shows whether each rejection path rejects and whether each valid code reaches the right state. Directed cases cover a frame cut short by start-of-frame, commands sent while a readout is transmitting, pointer wrap-around, and a scan stopped in the middle. Every packet is decoded from `mod_out` half-bit by half-bit and checked against the preamble, the converter value of the channel that was started, and a CRC the bench computes by long division.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int DATA_W = 8;
    localparam int CRC_W  = 3;
    localparam logic [7:0] PREAMBLE = 8'b1111_0000;

    typedef enum logic [2:0] {
        ST_IDLE, ST_TUNNEL, ST_INJECT, ST_SELECT, ST_READ, ST_SCAN
    } st_e;

    typedef enum logic [1:0] {PH_REQ, PH_WAIT, PH_TX} ph_e;

    // serial CRC over x^3+x+1, register cleared, data MSB first
    function automatic logic [CRC_W-1:0] crc3(input logic [DATA_W-1:0] d);
        logic [CRC_W-1:0] c;
        logic fb;
        c = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = c[2] ^ d[i];
            c  = {c[1], c[0] ^ fb, fb};
        end
        return c;
    endfunction
endpackage

// File: rtl/sc_cmd_rx.sv
module sc_cmd_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sof,
    input  logic       stb,
    input  logic       half,
    output logic       vld,
    output logic [3:0] code
);
    localparam int NHALF = 10;

    typedef struct packed {
        logic [3:0] cnt;
        logic [8:0] sr;
        logic       vld;
        logic [3:0] code;
    } rx_t;

    rx_t r_q, r_d;
    logic [9:0] full;
    logic [4:0] bits;
    logic       sym_ok;

    always_comb begin
        full   = {r_q.sr, half};
        sym_ok = 1'b1;
        for (int i = 0; i < 5; i++) begin
            sym_ok      = sym_ok & (full[9-2*i] ^ full[8-2*i]);
            bits[4-i]   = full[9-2*i];
        end
        r_d     = r_q;
        r_d.vld = 1'b0;
        if (sof) begin
            r_d.cnt = '0;
        end else if (stb) begin
            if (r_q.cnt == 4'(NHALF - 1)) begin
                r_d.cnt  = '0;
                r_d.vld  = sym_ok & ~(^bits);
                r_d.code = bits[4:1];
            end else begin
                r_d.cnt = r_q.cnt + 4'd1;
                r_d.sr  = {r_q.sr[7:0], half};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign vld  = r_q.vld;
    assign code = r_q.code;
endmodule

// File: rtl/sc_uplink_tx.sv
module sc_uplink_tx
    import sc_pkg::*;
#(
    parameter int HALF_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    output logic              done,
    output logic              mod_out
);
    localparam int FW  = 8 + DATA_W + CRC_W;
    localparam int BW  = $clog2(FW);
    localparam int TW  = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    typedef struct packed {
        logic          busy;
        logic [FW-1:0] frame;
        logic [BW-1:0] bidx;
        logic          second;
        logic [TW-1:0] tick;
    } tx_t;

    tx_t t_q, t_d;
    logic half_end;

    always_comb begin
        t_d      = t_q;
        half_end = t_q.busy && (t_q.tick == TW'(HALF_CYC - 1));
        done     = half_end && t_q.second && (t_q.bidx == '0);
        if (start && !t_q.busy) begin
            t_d.busy   = 1'b1;
            t_d.frame  = {PREAMBLE, data, crc3(data)};
            t_d.bidx   = BW'(FW - 1);
            t_d.second = 1'b0;
            t_d.tick   = '0;
        end else if (t_q.busy) begin
            if (half_end) begin
                t_d.tick = '0;
                if (!t_q.second) begin
                    t_d.second = 1'b1;
                end else begin
                    t_d.second = 1'b0;
                    if (t_q.bidx == '0) t_d.busy = 1'b0;
                    else                t_d.bidx = t_q.bidx - 1'b1;
                end
            end else begin
                t_d.tick = t_q.tick + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign mod_out = t_q.busy & (t_q.frame[t_q.bidx] ^ t_q.second);
endmodule

// File: rtl/sensor_ctrl.sv
module sensor_ctrl
    import sc_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int PULSE_LEN = 16,
    parameter int HALF_CYC  = 4,
    localparam int CH_W     = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_sof,
    input  logic              cmd_stb,
    input  logic              cmd_half,
    input  logic              adc_done,
    input  logic [DATA_W-1:0] adc_data,
    output logic              tun_en,
    output logic              inj_en,
    output logic              sel_en,
    output logic [CH_W-1:0]   ch_sel,
    output logic              adc_start,
    output logic              mod_out
);
    localparam int CNT_W = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        st_e             st;
        ph_e             ph;
        logic [CNT_W-1:0] cnt;
        logic [CH_W-1:0] ch;
        logic            stop;
    } fsm_t;

    fsm_t f_q, f_d;
    logic       cmd_vld;
    logic [3:0] cmd_code;
    logic       tx_start, tx_done;
    logic [CH_W-1:0] ch_inc;

    sc_cmd_rx u_rx (
        .clk  (clk),
        .rst_n(rst_n),
        .sof  (cmd_sof),
        .stb  (cmd_stb),
        .half (cmd_half),
        .vld  (cmd_vld),
        .code (cmd_code)
    );

    sc_uplink_tx #(.HALF_CYC(HALF_CYC)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tx_start),
        .data   (adc_data),
        .done   (tx_done),
        .mod_out(mod_out)
    );

    assign ch_inc = (f_q.ch == CH_W'(NUM_CH - 1)) ? '0 : f_q.ch + 1'b1;

    always_comb begin
        f_d      = f_q;
        tx_start = 1'b0;
        unique case (f_q.st)
            ST_IDLE: begin
                if (cmd_vld) begin
                    f_d.cnt = '0;
                    f_d.ph  = PH_REQ;
                    case (cmd_code)
                        4'd1: f_d.st = ST_TUNNEL;
                        4'd2: f_d.st = ST_INJECT;
                        4'd3: f_d.st = ST_SELECT;
                        4'd4: f_d.st = ST_READ;
                        4'd5: begin
                            f_d.st   = ST_SCAN;
                            f_d.ch   = '0;
                            f_d.stop = 1'b0;
                        end
                        default: ;
                    endcase
                end
            end
            ST_TUNNEL, ST_INJECT: begin
                if (f_q.cnt == CNT_W'(PULSE_LEN - 1)) f_d.st = ST_IDLE;
                else                                  f_d.cnt = f_q.cnt + 1'b1;
            end
            ST_SELECT: begin
                f_d.ch = ch_inc;
                f_d.st = ST_IDLE;
            end
            ST_READ, ST_SCAN: begin
                if (f_q.st == ST_SCAN && cmd_vld && cmd_code == 4'd0)
                    f_d.stop = 1'b1;
                unique case (f_q.ph)
                    PH_REQ:  f_d.ph = PH_WAIT;
                    PH_WAIT: begin
                        if (adc_done) begin
                            tx_start = 1'b1;
                            f_d.ph   = PH_TX;
                        end
                    end
                    PH_TX: begin
                        if (tx_done) begin
                            if (f_q.st == ST_READ || f_d.stop) begin
                                f_d.st = ST_IDLE;
                            end else begin
                                f_d.ch = ch_inc;
                                f_d.ph = PH_REQ;
                            end
                        end
                    end
                    default: f_d.ph = PH_REQ;
                endcase
            end
            default: f_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: ST_IDLE, ph: PH_REQ, cnt: '0, ch: '0, stop: 1'b0};
        else        f_q <= f_d;
    end

    assign tun_en    = (f_q.st == ST_TUNNEL);
    assign inj_en    = (f_q.st == ST_INJECT);
    assign sel_en    = (f_q.st == ST_SELECT);
    assign adc_start = (f_q.st == ST_READ || f_q.st == ST_SCAN) && (f_q.ph == PH_REQ);
    assign ch_sel    = f_q.ch;
endmodule

// File: rtl/sc_checker.sv
module sc_checker #(
    parameter int NUM_CH    = 4,
    parameter int PULSE_LEN = 16,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int RW       = $clog2(PULSE_LEN + 2)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tun_en,
    input logic            inj_en,
    input logic            sel_en,
    input logic            adc_start,
    input logic [CH_W-1:0] ch_sel,
    input logic            mod_out
);
    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                run_q <= '0;
        else if (tun_en || inj_en) run_q <= (run_q == RW'(PULSE_LEN + 1)) ? run_q : run_q + 1'b1;
        else                       run_q <= '0;
    end

    p_en_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tun_en, inj_en, sel_en, adc_start}));

    p_pulse_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(PULSE_LEN));

    p_sel_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_en |=> !sel_en);

    p_sel_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_en |=> (ch_sel == (($past(ch_sel) == CH_W'(NUM_CH - 1)) ? '0 : $past(ch_sel) + 1'b1)));

    p_start_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    p_read_ch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> $stable(ch_sel));

    p_quiet_during_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> !mod_out);
endmodule

bind sensor_ctrl sc_checker #(.NUM_CH(NUM_CH), .PULSE_LEN(PULSE_LEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tun_en   (tun_en),
    .inj_en   (inj_en),
    .sel_en   (sel_en),
    .adc_start(adc_start),
    .ch_sel   (ch_sel),
    .mod_out  (mod_out)
);

// File: tb/tb_sensor_ctrl.sv
module tb_sensor_ctrl;
    localparam int NUM_CH    = 4;
    localparam int PULSE_LEN = 16;
    localparam int HALF_CYC  = 4;
    localparam int CH_W      = $clog2(NUM_CH);
    localparam int NS        = 38 * HALF_CYC;
    localparam int ADC_LAT   = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_sof = 1'b0, cmd_stb = 1'b0, cmd_half = 1'b0;
    logic adc_done = 1'b0;
    logic [7:0] adc_data = 8'h00;
    logic tun_en, inj_en, sel_en, adc_start, mod_out;
    logic [CH_W-1:0] ch_sel;

    always #10 clk = ~clk;

    sensor_ctrl #(.NUM_CH(NUM_CH), .PULSE_LEN(PULSE_LEN), .HALF_CYC(HALF_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_sof(cmd_sof), .cmd_stb(cmd_stb), .cmd_half(cmd_half),
        .adc_done(adc_done), .adc_data(adc_data), .tun_en(tun_en), .inj_en(inj_en),
        .sel_en(sel_en), .ch_sel(ch_sel), .adc_start(adc_start), .mod_out(mod_out)
    );

    int checks = 0, errors = 0;
    int tun_cyc = 0, inj_cyc = 0, sel_cnt = 0, start_cnt = 0;
    int pkt_ok = 0, pkt_bad = 0, ord_bad = 0;
    int last_ch = 0, prev_ch = 0;
    bit scan_chk = 0, scan_first = 0;
    logic [7:0] chan_val [NUM_CH];
    int adc_cd = 0;
    logic [CH_W-1:0] exp_ch = '0;

    function automatic logic [2:0] ref_crc(input logic [7:0] d);
        logic [10:0] v;
        v = {d, 3'b000};
        for (int i = 10; i >= 3; i--)
            if (v[i]) v = v ^ (11'b1011 << (i - 3));
        return v[2:0];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr();
        tun_cyc = 0; inj_cyc = 0; sel_cnt = 0; start_cnt = 0;
        pkt_ok = 0; pkt_bad = 0; ord_bad = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_half(input logic h);
        @(negedge clk); cmd_stb = 1'b1; cmd_half = h;
        @(negedge clk); cmd_stb = 1'b0;
    endtask

    // kind 0 clean, 1 parity flipped, 2 one Manchester pair broken
    task automatic send_cmd(input logic [3:0] code, input int kind);
        logic [4:0] b;
        int bad_pos;
        b = {code, ^code};
        if (kind == 1) b[0] = ~b[0];
        bad_pos = (kind == 2) ? int'($urandom % 5) : -1;
        for (int i = 4; i >= 0; i--) begin
            if (i == bad_pos) begin
                send_half(b[i]);
                send_half(b[i]);
            end else begin
                send_half(b[i]);
                send_half(~b[i]);
            end
        end
    endtask

    // ADC model and output monitors, all on the falling edge
    logic samp [NS];
    int sidx = 0;
    bit cap = 0;
    always @(negedge clk) begin
        adc_done = 1'b0;
        if (adc_cd > 0) begin
            adc_cd--;
            if (adc_cd == 0) begin
                adc_done = 1'b1;
                adc_data = chan_val[last_ch];
            end
        end
        if (rst_n) begin
            if (tun_en) tun_cyc++;
            if (inj_en) inj_cyc++;
            if (sel_en) sel_cnt++;
            if (adc_start) begin
                start_cnt++;
                last_ch = int'(ch_sel);
                adc_cd = ADC_LAT;
                if (scan_chk) begin
                    if (scan_first) begin
                        if (last_ch != 0) ord_bad++;
                        scan_first = 0;
                    end else if (last_ch != (prev_ch + 1) % NUM_CH) ord_bad++;
                    prev_ch = last_ch;
                end
            end
            if (!cap && mod_out) begin
                cap = 1; sidx = 0;
            end
            if (cap) begin
                samp[sidx] = mod_out;
                sidx++;
                if (sidx == NS) begin
                    logic [18:0] fr;
                    bit good;
                    good = 1;
                    cap = 0;
                    for (int i = 0; i < 19; i++) begin
                        logic a, c;
                        a = samp[(2*i) * HALF_CYC + HALF_CYC/2];
                        c = samp[(2*i+1) * HALF_CYC + HALF_CYC/2];
                        if (a == c) good = 0;
                        fr[18-i] = a;
                    end
                    if (fr[18:11] != 8'hF0) good = 0;
                    if (fr[10:3] != chan_val[last_ch]) good = 0;
                    if (fr[2:0] != ref_crc(fr[10:3])) good = 0;
                    if (good) pkt_ok++;
                    else begin
                        pkt_bad++;
                        $display("bad packet frame=%b ch=%0d", fr, last_ch);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // bench model of the effect of one command from idle
    task automatic expect_cmd(input logic [3:0] code, input int kind);
        int et, ei, es, ep;
        et = 0; ei = 0; es = 0; ep = 0;
        if (kind == 0) begin
            case (code)
                4'd1: et = PULSE_LEN;
                4'd2: ei = PULSE_LEN;
                4'd3: es = 1;
                4'd4: ep = 1;
                default: ;
            endcase
        end
        clr();
        send_cmd(code, kind);
        wait_cyc(ep ? 260 : 50);
        if (es) exp_ch = (exp_ch == CH_W'(NUM_CH-1)) ? '0 : exp_ch + 1'b1;
        chk(tun_cyc == et, "R5 tunnel run", tun_cyc, et);
        chk(inj_cyc == ei, "R5 inject run", inj_cyc, ei);
        chk(sel_cnt == es, "R6 select pulses", sel_cnt, es);
        chk(ch_sel == exp_ch, "R6 channel pointer", int'(ch_sel), int'(exp_ch));
        chk(start_cnt == ep && pkt_ok == ep && pkt_bad == 0, "R7 R8 R9 readout packets", pkt_ok, ep);
        if (ep) chk(last_ch == int'(exp_ch), "R7 readout channel", last_ch, int'(exp_ch));
    endtask

    initial begin
        int r;
        r = $urandom(32'd2024);
        for (int i = 0; i < NUM_CH; i++) chan_val[i] = 8'($urandom);
        wait_cyc(5);
        // R1 reset state
        chk({tun_en, inj_en, sel_en, adc_start, mod_out} == 5'b0, "R1 outputs in reset",
            int'({tun_en, inj_en, sel_en, adc_start, mod_out}), 0);
        rst_n = 1'b1;
        wait_cyc(3);
        chk(ch_sel == '0 && !mod_out && !tun_en, "R1 state after reset", int'(ch_sel), 0);

        // R4 R5 basic codes
        expect_cmd(4'd1, 0);
        expect_cmd(4'd2, 0);
        // R6 wrap-around
        for (int k = 0; k < NUM_CH + 1; k++) expect_cmd(4'd3, 0);
        // R7 R8 R9 readout on channel 1
        expect_cmd(4'd4, 0);
        // R3 parity and R2 Manchester rejects
        expect_cmd(4'd1, 1);
        expect_cmd(4'd2, 2);
        expect_cmd(4'd4, 1);
        // R4 unused codes are ignored in idle
        expect_cmd(4'd0, 0);
        expect_cmd(4'd9, 0);
        expect_cmd(4'd15, 0);

        // R2 start-of-frame drops a partial frame
        clr();
        send_half(1'b1); send_half(1'b0); send_half(1'b0); send_half(1'b1);
        @(negedge clk); cmd_sof = 1'b1;
        @(negedge clk); cmd_sof = 1'b0;
        send_cmd(4'd2, 0);
        wait_cyc(50);
        chk(inj_cyc == PULSE_LEN && tun_cyc == 0, "R2 sof restarts frame", inj_cyc, PULSE_LEN);

        // R4 a command during a readout is ignored
        clr();
        send_cmd(4'd4, 0);
        wait_cyc(30);
        send_cmd(4'd1, 0);
        wait_cyc(250);
        chk(tun_cyc == 0, "R4 command ignored while busy", tun_cyc, 0);
        chk(pkt_ok == 1 && pkt_bad == 0, "R8 packet during ignored command", pkt_ok, 1);

        // random mix of codes and corruptions
        for (int n = 0; n < 30; n++) begin
            logic [3:0] c;
            int kd;
            c = 4'($urandom % 16);
            if (c == 4'd5) c = 4'd4;
            kd = int'($urandom % 3);
            expect_cmd(c, kd);
        end

        // R10 R11 continuous scan and stop
        clr();
        scan_chk = 1; scan_first = 1;
        send_cmd(4'd5, 0);
        wait_cyc(700);
        send_cmd(4'd0, 0);
        wait_cyc(400);
        chk(start_cnt >= NUM_CH + 1, "R10 scan wraps channels", start_cnt, NUM_CH + 1);
        chk(ord_bad == 0, "R10 scan channel order", ord_bad, 0);
        chk(pkt_bad == 0 && pkt_ok == start_cnt, "R11 last packet completed", pkt_ok, start_cnt);
        r = start_cnt;
        wait_cyc(400);
        chk(start_cnt == r, "R11 no starts after stop", start_cnt, r);
        scan_chk = 0;
        clr();
        send_cmd(4'd1, 0);
        wait_cyc(50);
        chk(tun_cyc == PULSE_LEN, "R11 idle accepts commands again", tun_cyc, PULSE_LEN);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule